// File: doc/BRIEF.md
# Accumulator Scaling Shifter with Exponent Encoder

This block scales a 40-bit accumulator value in one registered cycle. A plain shift operation moves the value left or right by a signed count. That count comes from one of three sources: a count field taken from the instruction word, a shift field held in a status register, or the low bits of the temporary register T. On a right shift, a mode input decides whether the vacated upper bits receive zeros or copies of bit 39.

The block also contains an exponent encoder. On every accepted input, the encoder reports how many copies of the sign bit sit above the significant bits. The count is expressed relative to bit 31, so it goes negative when the guard bits carry information. A normalize operation feeds this exponent straight into the shifter. In the same cycle it returns the value with bit 31 as the first significant bit, together with the exponent that the surrounding datapath would write into T. Instruction decode and register storage stay outside the block, and all count sources and the mode bit arrive as ports.

Top module: `acc_scaler`

## Requirements
- R1: Each input accepted with `in_valid` high gives `out_valid` high exactly one clock later, with `dout` and `exp_cnt` updated in that same cycle. When `in_valid` is low, `out_valid` returns low and `dout` and `exp_cnt` keep their values.
- R2: When `op_norm` is 0, the shift count is chosen by `cnt_sel`. The value 0 selects `instr_cnt`, 1 selects `stat_cnt`, and 2 or 3 select `t_reg[5:0]`. The count is a 6-bit two's-complement number, where positive means a left shift and negative means a right shift.
- R3: A left shift by 0 to 31 fills the vacated low bits with zeros and discards bits moved beyond bit 39.
- R4: On a right shift, the vacated high bits are copies of `din[39]` when `sign_ext` is 1 and zeros when `sign_ext` is 0.
- R5: Right-shift counts from -17 to -32 are clamped and behave exactly as -16.
- R6: `exp_cnt` is a 6-bit two's-complement value equal to the number of consecutive bits below bit 39 that match bit 39, minus 8. Its range is -8 to 31, and it is produced for both operations.
- R7: When `op_norm` is 1, `dout` is `din` shifted left by `exp_cnt` when that is positive, or arithmetically right by its magnitude when negative. `sign_ext` is ignored. For any input other than all zeros or all ones, the result has bit 31 different from bit 30.
- R8: An all-zero or all-one input gives `exp_cnt` = 31. Normalizing all ones gives 40'hFF_8000_0000, and normalizing zero gives zero.
- R9: While `rst` is high, `out_valid`, `dout` and `exp_cnt` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and controls are valid this cycle |
| op_norm | input | 1 | 1 = normalize, 0 = shift by selected count |
| cnt_sel | input | 2 | Count source: 0 instruction field, 1 status field, 2/3 T register |
| instr_cnt | input | 6 | Signed count from the instruction field |
| stat_cnt | input | 6 | Signed count from the status-register field |
| t_reg | input | 16 | Temporary register; bits 5:0 used as signed count |
| sign_ext | input | 1 | Right-shift fill: 1 sign copies, 0 zeros |
| din | input | 40 | Accumulator value |
| out_valid | output | 1 | Registered result valid |
| dout | output | 40 | Registered shifted or normalized value |
| exp_cnt | output | 6 | Registered signed leading-redundancy exponent |

## Verification
The exponent encoder and the shifter act on the same input in the same cycle. A normalize operation even chains them, so a single registered edge has to capture both the exponent and the value shifted by that exponent. The bench drives back-to-back normalize and shift words. Their inputs carry sign runs of every length, including runs that reach into the guard bits and the all-zero and all-one extremes. A scoreboard then compares each output pair against a bit-serial reference model, so that an exponent from one word paired with a shift from another shows up as a mismatch.

// File: rtl/acc_scaler_pkg.sv
package acc_scaler_pkg;
  localparam int ACC_W   = 40;
  localparam int GUARD_W = 8;
  localparam int CNT_W   = 6;
  localparam int TREG_W  = 16;
  localparam int RSH_MAX = 16;
  localparam int LSH_MAX = 31;

  typedef enum logic [1:0] {
    SRC_INSTR = 2'd0,
    SRC_STAT  = 2'd1,
    SRC_TREG  = 2'd2,
    SRC_TALT  = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/scale_cnt_sel.sv
module scale_cnt_sel #(
  parameter int CNT_W   = 6,
  parameter int TREG_W  = 16,
  parameter int RSH_MAX = 16,
  parameter int LSH_MAX = 31
) (
  input  logic [1:0]              sel,
  input  logic [CNT_W-1:0]        instr_cnt,
  input  logic [CNT_W-1:0]        stat_cnt,
  input  logic [TREG_W-1:0]       t_reg,
  output logic signed [CNT_W-1:0] amt
);
  import acc_scaler_pkg::*;

  localparam logic signed [CNT_W-1:0] NEG_LIM = CNT_W'(-RSH_MAX);
  localparam logic signed [CNT_W-1:0] POS_LIM = CNT_W'(LSH_MAX);

  logic signed [CNT_W-1:0] raw;

  always_comb begin
    unique case (cnt_src_e'(sel))
      SRC_INSTR: raw = instr_cnt;
      SRC_STAT:  raw = stat_cnt;
      default:   raw = t_reg[CNT_W-1:0];
    endcase
    if (raw < NEG_LIM)      amt = NEG_LIM;
    else if (raw > POS_LIM) amt = POS_LIM;
    else                    amt = raw;
  end
endmodule

// File: rtl/lead_sign_enc.sv
module lead_sign_enc #(
  parameter int DW    = 40,
  parameter int GUARD = 8,
  parameter int CNT_W = 6
) (
  input  logic [DW-1:0]           din,
  output logic signed [CNT_W-1:0] exp_val
);
  localparam int RW = $clog2(DW) + 1;

  logic [RW-1:0] run_len;
  logic          in_run;

  always_comb begin
    run_len = '0;
    in_run  = 1'b1;
    for (int i = DW - 2; i >= 0; i--) begin
      if (in_run && (din[i] == din[DW-1])) run_len = run_len + 1'b1;
      else                                  in_run  = 1'b0;
    end
    exp_val = CNT_W'(int'(run_len) - GUARD);
  end
endmodule

// File: rtl/bar_shift40.sv
module bar_shift40 #(
  parameter int DW    = 40,
  parameter int CNT_W = 6
) (
  input  logic [DW-1:0]           din,
  input  logic signed [CNT_W-1:0] amt,
  input  logic                    fill_sign,
  output logic [DW-1:0]           dout
);
  logic [CNT_W-1:0]  mag;
  logic              ext;
  logic [2*DW-1:0]   wide;

  always_comb begin
    ext  = fill_sign & din[DW-1];
    mag  = amt[CNT_W-1] ? CNT_W'(-amt) : CNT_W'(amt);
    wide = {{DW{ext}}, din} >> mag;
    if (amt[CNT_W-1]) dout = wide[DW-1:0];
    else              dout = din << mag;
  end
endmodule

// File: rtl/acc_scaler.sv
module acc_scaler #(
  parameter int ACC_W   = acc_scaler_pkg::ACC_W,
  parameter int GUARD_W = acc_scaler_pkg::GUARD_W,
  parameter int CNT_W   = acc_scaler_pkg::CNT_W,
  parameter int TREG_W  = acc_scaler_pkg::TREG_W,
  parameter int RSH_MAX = acc_scaler_pkg::RSH_MAX,
  parameter int LSH_MAX = acc_scaler_pkg::LSH_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_norm,
  input  logic [1:0]        cnt_sel,
  input  logic [CNT_W-1:0]  instr_cnt,
  input  logic [CNT_W-1:0]  stat_cnt,
  input  logic [TREG_W-1:0] t_reg,
  input  logic              sign_ext,
  input  logic [ACC_W-1:0]  din,
  output logic              out_valid,
  output logic [ACC_W-1:0]  dout,
  output logic [CNT_W-1:0]  exp_cnt
);
  logic signed [CNT_W-1:0] sel_amt;
  logic signed [CNT_W-1:0] enc_exp;
  logic signed [CNT_W-1:0] use_amt;
  logic                    use_fill;
  logic [ACC_W-1:0]        shifted;

  scale_cnt_sel #(
    .CNT_W(CNT_W), .TREG_W(TREG_W), .RSH_MAX(RSH_MAX), .LSH_MAX(LSH_MAX)
  ) u_cnt (
    .sel(cnt_sel), .instr_cnt(instr_cnt), .stat_cnt(stat_cnt),
    .t_reg(t_reg), .amt(sel_amt)
  );

  lead_sign_enc #(
    .DW(ACC_W), .GUARD(GUARD_W), .CNT_W(CNT_W)
  ) u_enc (
    .din(din), .exp_val(enc_exp)
  );

  always_comb begin
    use_amt  = op_norm ? enc_exp : sel_amt;
    use_fill = op_norm ? 1'b1    : sign_ext;
  end

  bar_shift40 #(
    .DW(ACC_W), .CNT_W(CNT_W)
  ) u_shift (
    .din(din), .amt(use_amt), .fill_sign(use_fill), .dout(shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
      exp_cnt   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dout    <= shifted;
        exp_cnt <= enc_exp;
      end
    end
  end
endmodule

// File: rtl/acc_scaler_chk.sv
module acc_scaler_chk #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             op_norm,
  input logic [ACC_W-1:0] din,
  input logic             out_valid,
  input logic [ACC_W-1:0] dout,
  input logic [CNT_W-1:0] exp_cnt
);
  localparam logic signed [CNT_W-1:0] EXP_MIN  = CNT_W'(-GUARD_W);
  localparam logic [CNT_W-1:0]        EXP_FULL = CNT_W'(ACC_W - 1 - GUARD_W);

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(dout) && $stable(exp_cnt)));

  p_exp_floor_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(exp_cnt) >= EXP_MIN));

  p_norm_justified_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_norm && (din != '0) && (din != '1)) |=> (dout[31] != dout[30]));

  p_flat_exp_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((din == '0) || (din == '1))) |=> (exp_cnt == EXP_FULL));
endmodule

bind acc_scaler acc_scaler_chk #(
  .ACC_W(ACC_W), .GUARD_W(GUARD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_norm(op_norm), .din(din),
  .out_valid(out_valid), .dout(dout), .exp_cnt(exp_cnt)
);

// File: tb/acc_scaler_tb_top.sv
module acc_scaler_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_norm = 1'b0;
  logic [1:0]  cnt_sel = 2'd0;
  logic [5:0]  instr_cnt = '0;
  logic [5:0]  stat_cnt = '0;
  logic [15:0] t_reg = '0;
  logic        sign_ext = 1'b0;
  logic [39:0] din = '0;
  logic        out_valid;
  logic [39:0] dout;
  logic [5:0]  exp_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [39:0] q_dout[$];
  logic [5:0]  q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  acc_scaler dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_norm(op_norm),
    .cnt_sel(cnt_sel), .instr_cnt(instr_cnt), .stat_cnt(stat_cnt),
    .t_reg(t_reg), .sign_ext(sign_ext), .din(din),
    .out_valid(out_valid), .dout(dout), .exp_cnt(exp_cnt)
  );

  function automatic logic [5:0] m_exp(logic [39:0] v);
    int k = 0;
    for (int i = 38; i >= 0; i--) begin
      if (v[i] != v[39]) break;
      k++;
    end
    return 6'(k - 8);
  endfunction

  function automatic logic [39:0] m_shift(logic [39:0] v, int amt, bit arith);
    logic [39:0] r = v;
    if (amt >= 0) begin
      for (int i = 0; i < amt; i++) r = {r[38:0], 1'b0};
    end else begin
      int n = -amt;
      if (n > 16) n = 16;
      for (int i = 0; i < n; i++) r = {arith ? r[39] : 1'b0, r[39:1]};
    end
    return r;
  endfunction

  task automatic check(string tag, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(bit nrm, logic [1:0] sel, logic [5:0] ic, logic [5:0] sc,
                       logic [15:0] t, bit sx, logic [39:0] d, string tag);
    logic [5:0] c;
    logic [5:0] e;
    @(negedge clk);
    in_valid = 1'b1; op_norm = nrm; cnt_sel = sel; instr_cnt = ic;
    stat_cnt = sc; t_reg = t; sign_ext = sx; din = d;
    e = m_exp(d);
    c = (sel == 2'd0) ? ic : (sel == 2'd1) ? sc : t[5:0];
    q_exp.push_back(e);
    q_tag.push_back(tag);
    if (nrm) q_dout.push_back(m_shift(d, int'($signed(e)), 1'b1));
    else     q_dout.push_back(m_shift(d, int'($signed(c)), sx));
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_dout.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
      end else begin
        string tg = q_tag.pop_front();
        check(tg, "dout", dout, q_dout.pop_front());
        check(tg, "exp_cnt", 40'(exp_cnt), 40'(q_exp.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [39:0] held_d;
    logic [5:0]  held_e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", "out_valid", 40'(out_valid), 40'd0);
    check("R9", "dout", dout, 40'd0);
    check("R9", "exp_cnt", 40'(exp_cnt), 40'd0);
    rst = 1'b0;

    // R3 left shifts, zero fill at bottom
    drive(0, 2'd0, 6'd31, 6'd0, 16'd0, 1, 40'h00_0000_0001, "R3");
    drive(0, 2'd0, 6'd8,  6'd0, 16'd0, 1, 40'hFF_FFFF_FFFF, "R3");
    drive(0, 2'd0, 6'd0,  6'd0, 16'd0, 0, 40'h12_3456_789A, "R3");
    // R4 right fill by mode bit
    drive(0, 2'd1, 6'd0, 6'h30, 16'd0, 1, 40'h80_0000_0000, "R4");
    drive(0, 2'd1, 6'd0, 6'h30, 16'd0, 0, 40'h80_0000_0000, "R4");
    drive(0, 2'd1, 6'd0, 6'h3F, 16'd0, 1, 40'hF0_0000_0003, "R4");
    // R5 clamp of long right counts
    drive(0, 2'd2, 6'd0, 6'd0, 16'h00EC, 1, 40'h80_0000_0000, "R5");
    drive(0, 2'd3, 6'd0, 6'd0, 16'hFFE0, 0, 40'hFF_FFFF_0000, "R5");
    drive(0, 2'd2, 6'd0, 6'd0, 16'h002F, 1, 40'hC0_0000_0000, "R5");
    // R2 source selection with distinct counts
    drive(0, 2'd0, 6'd5,  6'h3D, 16'h0007, 1, 40'h00_0000_00FF, "R2");
    drive(0, 2'd1, 6'd5,  6'h3D, 16'h0007, 1, 40'h00_0000_00FF, "R2");
    drive(0, 2'd2, 6'd5,  6'h3D, 16'hFF07, 1, 40'h00_0000_00FF, "R2");
    // R6/R7/R8 exponent and normalize
    drive(1, 2'd0, 6'd3, 6'd0, 16'd0, 0, 40'h00_0000_0000, "R8");
    drive(1, 2'd0, 6'd3, 6'd0, 16'd0, 0, 40'hFF_FFFF_FFFF, "R8");
    drive(1, 2'd0, 6'd0, 6'd0, 16'd0, 0, 40'h7F_FFFF_FFFF, "R6");
    drive(1, 2'd0, 6'd0, 6'd0, 16'd0, 0, 40'h00_0000_4000, "R7");
    drive(1, 2'd0, 6'd0, 6'd0, 16'd0, 0, 40'hFF_C000_0000, "R7");
    drive(1, 2'd0, 6'd0, 6'd0, 16'd0, 0, 40'h03_0000_0000, "R7");

    // Random words with random sign-run lengths, both operations back to back
    for (int n = 0; n < 400; n++) begin
      logic [39:0] v;
      bit nrm;
      v = {8'($urandom), 32'($urandom)};
      v = 40'($signed(v) >>> ($urandom % 40));
      nrm = $urandom % 2;
      drive(nrm, 2'($urandom), 6'($urandom), 6'($urandom), 16'($urandom),
            1'($urandom), v, nrm ? "R7" : "R2");
    end

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    // R1: outputs hold while idle
    held_d = dout;
    held_e = exp_cnt;
    repeat (3) @(negedge clk);
    check("R1", "idle out_valid", 40'(out_valid), 40'd0);
    check("R1", "idle dout", dout, held_d);
    check("R1", "idle exp_cnt", 40'(exp_cnt), 40'(held_e));
    check("R1", "pending results", 40'(q_dout.size()), 40'd0);
    finish_run();
  end
endmodule